// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable model of a serial EEPROM slave with a chip select, a serial clock, a data input and a data output that can be turned off. A host sends a frame: a start bit, a two-bit opcode and an eight-bit address, followed by sixteen data bits when the instruction carries data. The block stores 256 words of 16 bits in an internal register file. It can read a word, program a single word, erase a single word, fill every word, clear every word, and set or clear a write-enable latch.

All pins are sampled by a fast system clock, and the block acts on the edges it finds in those samples. Programming is self-timed and its length is counted in system clocks. It begins when chip select falls after a complete programming frame. If the host raises chip select again while the cycle is still running, the data output reports the cycle's progress. That report is cleared by a serial clock rising edge while chip select and data in are both high.

Top module: `uwire_eeprom`

## Requirements
- R1: After reset the write-enable latch is clear and dout_oe and dout are 0. A reset applied after an enable clears the latch again.
- R2: The latch is set by the enable instruction. It stays set across any number of programming operations until the disable instruction or reset.
- R3: While the latch is clear, word program, word erase, fill and clear instructions change no word and start no programming cycle.
- R4: A programming cycle starts when chip select falls after the last data bit (for the program and fill instructions) or after the last address bit (for the erase and clear instructions).
- R5: When chip select is raised while a cycle runs, dout_oe is 1 and dout is 0 until the cycle ends, after which dout is 1.
- R6: Erase sets the addressed word to 16'hFFFF and leaves the other words unchanged. Clear sets every word to 16'hFFFF.
- R7: Fill writes the 16-bit word carried in the frame to every address.
- R8: A serial clock rising edge with chip select and data in both high clears the status output (dout_oe goes to 0). When the block is idle, the same edge is also taken as the start bit of a new frame.
- R9: When chip select is raised only after the cycle has ended, dout_oe stays 0.
- R10: Frame bits that arrive while a cycle runs are ignored, and no read data is driven.
- R11: A frame is a start bit of 1, then the opcode MSB first, then the address MSB first. The opcodes are 2'b10 read, 2'b01 program word and 2'b11 erase word. Opcode 2'b00 selects an instruction from the top two address bits: 2'b00 disable, 2'b01 fill, 2'b10 clear, 2'b11 enable.
- R12: A read drives a 0 after the last address bit. It then drives the 16 data bits MSB first, one per later serial clock rising edge, with dout_oe at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data or status to the host |
| dout_oe | output | 1 | Output enable for dout |

## Verification
The interesting coincidence is the serial clock edge that clears the ready status: when the block is idle, that same edge must also be accepted as a new start bit. To provoke it, the bench raises chip select during a cycle, waits until the ready value appears, and then issues a read whose start bit doubles as the clear condition. It judges the result by dout_oe dropping after that first edge and by the read returning the expected word. A second overlap sends a complete read frame while a cycle is still counting. The bench expects the status to be cleared and no read data to appear, then later reads the word that cycle programmed.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } opc_e;

  typedef enum logic [1:0] {
    EX_DIS   = 2'b00,
    EX_FILL  = 2'b01,
    EX_CLEAR = 2'b10,
    EX_EN    = 2'b11
  } ext_e;

  typedef enum logic [1:0] {
    PK_WORD,
    PK_ERASE,
    PK_FILL,
    PK_CLEAR
  } pkind_e;

  typedef enum logic [2:0] {
    F_IDLE,
    F_OPC,
    F_ADDR,
    F_DATA,
    F_RDOUT,
    F_ARM,
    F_HOLD
  } fstate_e;

endpackage

// File: rtl/uwire_store.sv
module uwire_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // one write port and one registered read port, no reset on the array
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/uwire_frame.sv
module uwire_frame
  import uwire_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_cs,
  input  logic              s_din,
  input  logic              sk_rise,
  input  logic              cs_fall,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_q,
  output logic              go,
  output pkind_e            kind,
  output logic [ADDR_W-1:0] p_addr,
  output logic [DATA_W-1:0] p_data,
  output logic              wen_set,
  output logic              wen_clr,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_oe,
  output logic              rd_bit
);
  localparam int MAXW = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int CNT_W = $clog2(MAXW + 1);

  fstate_e            state;
  logic [CNT_W-1:0]   bitcnt;
  logic [1:0]         opc_r;
  logic [ADDR_W-1:0]  addr_r;
  logic [DATA_W-1:0]  data_r;
  logic [DATA_W:0]    shreg;
  logic               rd_pend;

  logic [ADDR_W-1:0]  nxt_addr;
  logic               addr_done;
  opc_e               opc;
  ext_e               sub;

  always_comb begin
    nxt_addr  = {addr_r[ADDR_W-2:0], s_din};
    opc       = opc_e'(opc_r);
    sub       = ext_e'(nxt_addr[ADDR_W-1 -: 2]);
    addr_done = s_cs && sk_rise && (state == F_ADDR) &&
                (bitcnt == CNT_W'(ADDR_W - 1));
    wen_set   = addr_done && (opc == OP_EXT) && (sub == EX_EN);
    wen_clr   = addr_done && (opc == OP_EXT) && (sub == EX_DIS);
    rd_en     = addr_done && (opc == OP_READ);
    rd_addr   = nxt_addr;
    go        = cs_fall && (state == F_ARM);
    rd_oe     = (state == F_RDOUT);
    rd_bit    = shreg[DATA_W];
    p_addr    = addr_r;
    p_data    = data_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= F_IDLE;
      bitcnt  <= '0;
      opc_r   <= '0;
      addr_r  <= '0;
      data_r  <= '0;
      kind    <= PK_WORD;
      shreg   <= '0;
      rd_pend <= 1'b0;
    end else begin
      rd_pend <= rd_en;
      if (rd_pend) shreg <= {1'b0, rd_q};
      if (!s_cs) begin
        state <= F_IDLE;
      end else if (sk_rise) begin
        case (state)
          F_IDLE: begin
            if (s_din && !busy) begin
              state  <= F_OPC;
              bitcnt <= '0;
            end
          end
          F_OPC: begin
            opc_r  <= {opc_r[0], s_din};
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == CNT_W'(1)) begin
              state  <= F_ADDR;
              bitcnt <= '0;
            end
          end
          F_ADDR: begin
            addr_r <= nxt_addr;
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == CNT_W'(ADDR_W - 1)) begin
              bitcnt <= '0;
              case (opc)
                OP_READ: begin
                  state <= F_RDOUT;
                  shreg <= '0;
                end
                OP_WRITE: begin
                  state <= F_DATA;
                  kind  <= PK_WORD;
                end
                OP_ERASE: begin
                  state <= F_ARM;
                  kind  <= PK_ERASE;
                end
                default: begin
                  case (sub)
                    EX_FILL: begin
                      state <= F_DATA;
                      kind  <= PK_FILL;
                    end
                    EX_CLEAR: begin
                      state <= F_ARM;
                      kind  <= PK_CLEAR;
                    end
                    default: state <= F_HOLD;
                  endcase
                end
              endcase
            end
          end
          F_DATA: begin
            data_r <= {data_r[DATA_W-2:0], s_din};
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == CNT_W'(DATA_W - 1)) begin
              state  <= F_ARM;
              bitcnt <= '0;
            end
          end
          F_RDOUT: begin
            shreg  <= {shreg[DATA_W-1:0], 1'b0};
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == CNT_W'(DATA_W)) state <= F_HOLD;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/uwire_prog.sv
module uwire_prog
  import uwire_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  pkind_e            kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              wen_set,
  input  logic              wen_clr,
  output logic              busy,
  output logic              wen,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BULK  = (PROG_CYCLES > DEPTH) ? PROG_CYCLES : DEPTH;
  localparam int CW    = $clog2(BULK + 1);

  logic [CW-1:0]     cnt;
  logic [CW-1:0]     limit;
  pkind_e            kind_r;
  logic [ADDR_W-1:0] addr_r;
  logic [DATA_W-1:0] data_r;
  logic              bulk;
  logic              ones;

  always_comb begin
    bulk  = (kind_r == PK_FILL) || (kind_r == PK_CLEAR);
    ones  = (kind_r == PK_ERASE) || (kind_r == PK_CLEAR);
    limit = bulk ? CW'(BULK) : CW'(PROG_CYCLES);
    we    = busy && (bulk ? (cnt < CW'(DEPTH)) : (cnt == '0));
    waddr = bulk ? cnt[ADDR_W-1:0] : addr_r;
    wdata = ones ? '1 : data_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      wen    <= 1'b0;
      cnt    <= '0;
      kind_r <= PK_WORD;
      addr_r <= '0;
      data_r <= '0;
    end else begin
      if (wen_set)      wen <= 1'b1;
      else if (wen_clr) wen <= 1'b0;
      if (!busy && go && wen) begin
        busy   <= 1'b1;
        cnt    <= '0;
        kind_r <= kind;
        addr_r <= addr;
        data_r <= data;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == limit - 1'b1) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uwire_eeprom.sv
module uwire_eeprom
  import uwire_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sk,
  input  logic din,
  output logic dout,
  output logic dout_oe
);
  logic cs_q, cs_qq, sk_q, sk_qq, din_q;
  logic sk_rise, cs_fall, cs_rise;
  logic stat_on;

  logic              go_w, busy_w, wen_w, wen_set_w, wen_clr_w;
  pkind_e            kind_w;
  logic [ADDR_W-1:0] p_addr_w, rd_addr_w, waddr_w;
  logic [DATA_W-1:0] p_data_w, rd_q_w, wdata_w;
  logic              rd_en_w, rd_oe_w, rd_bit_w, we_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q <= 1'b0; cs_qq <= 1'b0;
      sk_q <= 1'b0; sk_qq <= 1'b0;
      din_q <= 1'b0;
    end else begin
      cs_q <= cs;  cs_qq <= cs_q;
      sk_q <= sk;  sk_qq <= sk_q;
      din_q <= din;
    end
  end

  assign sk_rise = sk_q & ~sk_qq;
  assign cs_fall = ~cs_q & cs_qq;
  assign cs_rise = cs_q & ~cs_qq;

  always_ff @(posedge clk) begin
    if (rst)                          stat_on <= 1'b0;
    else if (!cs_q || (sk_rise && din_q)) stat_on <= 1'b0;
    else if (cs_rise && busy_w)       stat_on <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= 1'b0;
      dout_oe <= 1'b0;
    end else begin
      dout    <= rd_oe_w ? rd_bit_w : (stat_on & ~busy_w);
      dout_oe <= rd_oe_w | stat_on;
    end
  end

  uwire_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst(rst), .s_cs(cs_q), .s_din(din_q),
    .sk_rise(sk_rise), .cs_fall(cs_fall), .busy(busy_w), .rd_q(rd_q_w),
    .go(go_w), .kind(kind_w), .p_addr(p_addr_w), .p_data(p_data_w),
    .wen_set(wen_set_w), .wen_clr(wen_clr_w), .rd_en(rd_en_w),
    .rd_addr(rd_addr_w), .rd_oe(rd_oe_w), .rd_bit(rd_bit_w)
  );

  uwire_prog #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk(clk), .rst(rst), .go(go_w), .kind(kind_w), .addr(p_addr_w),
    .data(p_data_w), .wen_set(wen_set_w), .wen_clr(wen_clr_w),
    .busy(busy_w), .wen(wen_w), .we(we_w), .waddr(waddr_w), .wdata(wdata_w)
  );

  uwire_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .we(we_w), .waddr(waddr_w), .wdata(wdata_w),
    .re(rd_en_w), .raddr(rd_addr_w), .rdata(rd_q_w)
  );
endmodule

// File: rtl/uwire_chk.sv
module uwire_chk (
  input logic clk,
  input logic rst,
  input logic wen,
  input logic go,
  input logic busy,
  input logic stat_on,
  input logic cs_q,
  input logic din_q,
  input logic sk_rise,
  input logic cs_rise
);
  // R1: latch is clear when reset is released
  p_wen_off_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !wen);

  // R3: a locked start request starts no cycle
  p_locked_r3: assert property (@(posedge clk) disable iff (rst)
    (go && !wen) |=> !busy);

  // R4: a cycle begins only after an enabled chip-select fall
  p_start_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(go && wen));

  // R8: the clear condition drops the status flag
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (cs_q && sk_rise && din_q) |=> !stat_on);

  // R9: raising chip select after the cycle gives no status
  p_late_r9: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && !busy) |=> !stat_on);
endmodule

bind uwire_eeprom uwire_chk u_chk (
  .clk(clk), .rst(rst), .wen(wen_w), .go(go_w), .busy(busy_w),
  .stat_on(stat_on), .cs_q(cs_q), .din_q(din_q),
  .sk_rise(sk_rise), .cs_rise(cs_rise)
);

// File: tb/tb_uwire_eeprom.sv
module tb_uwire_eeprom;
  localparam int PROG = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, sk = 1'b0, din = 1'b0;
  logic dout, dout_oe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct { string tag; logic [15:0] val; } exp_t;
  exp_t        expq[$];
  logic [15:0] gotq[$];

  always #2 clk = ~clk;

  uwire_eeprom #(.ADDR_W(8), .DATA_W(16), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst(rst), .cs(cs), .sk(sk), .din(din),
    .dout(dout), .dout_oe(dout_oe)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clk_bit(logic b);
    din = b; tick(4); sk = 1'b1; tick(4); sk = 1'b0;
  endtask

  task automatic send_head(logic [1:0] op, logic [7:0] a);
    cs = 1'b1; tick(2);
    clk_bit(1'b1);
    clk_bit(op[1]); clk_bit(op[0]);
    for (int i = 7; i >= 0; i--) clk_bit(a[i]);
  endtask

  task automatic end_cs;
    din = 1'b0; cs = 1'b0; tick(4);
  endtask

  task automatic ext(logic [1:0] sub);
    send_head(2'b00, {sub, 6'b0}); end_cs;
  endtask

  task automatic send_data(logic [15:0] d);
    for (int i = 15; i >= 0; i--) clk_bit(d[i]);
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    send_head(2'b01, a); send_data(d); end_cs;
  endtask

  // driver: pushes the expected word, captures the serial word for the monitor
  task automatic rd(logic [7:0] a, logic [15:0] exp, string tag);
    logic [15:0] w;
    expq.push_back('{tag, exp});
    cs = 1'b1; tick(2);
    clk_bit(1'b1);
    chk({tag, " R8 start edge leaves dout_oe low"}, {31'b0, dout_oe}, 32'd0);
    clk_bit(1'b1); clk_bit(1'b0);
    for (int i = 7; i >= 0; i--) clk_bit(a[i]);
    chk("R12 dummy zero", {30'b0, dout_oe, dout}, 32'd2);
    for (int i = 15; i >= 0; i--) begin
      clk_bit(1'b0);
      w[i] = dout;
    end
    gotq.push_back(w);
    end_cs;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      while (gotq.size() > 0 && expq.size() > 0) begin
        logic [15:0] g;
        exp_t e;
        g = gotq.pop_front();
        e = expq.pop_front();
        total++;
        if (g !== e.val) begin
          bad++;
          $display("FAIL %s read actual=%h expected=%h", e.tag, g, e.val);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(5); rst = 1'b0; tick(3);
    chk("R1 reset outputs", {30'b0, dout_oe, dout}, 32'd0);

    // locked program: no cycle, no status
    wr(8'h05, 16'h1234);
    cs = 1'b1; tick(6);
    chk("R3 locked program gives no status", {31'b0, dout_oe}, 32'd0);
    cs = 1'b0; tick(4);

    // enable, clear all, watch busy then ready
    ext(2'b11);
    send_head(2'b00, {2'b10, 6'b0}); end_cs;
    cs = 1'b1; tick(6);
    chk("R5 busy status", {30'b0, dout_oe, dout}, 32'd2);
    tick(300);
    chk("R5 ready status", {30'b0, dout_oe, dout}, 32'd3);
    rd(8'h05, 16'hFFFF, "R6");

    // latch still set: program word
    wr(8'h05, 16'h1234);
    cs = 1'b1; tick(6);
    chk("R5 busy after word program", {30'b0, dout_oe, dout}, 32'd2);
    tick(PROG + 20);
    chk("R5 ready after word program", {30'b0, dout_oe, dout}, 32'd3);
    rd(8'h05, 16'h1234, "R2");

    // frame while busy is ignored
    wr(8'hA0, 16'hBEEF);
    send_head(2'b10, 8'hA0);
    for (int i = 0; i < 4; i++) clk_bit(1'b0);
    chk("R10 no read data while busy", {31'b0, dout_oe}, 32'd0);
    end_cs; tick(PROG + 50);
    rd(8'hA0, 16'hBEEF, "R10");

    // late raise of chip select
    wr(8'h07, 16'h00FF);
    tick(PROG + 50);
    cs = 1'b1; tick(6);
    chk("R9 late raise gives no status", {31'b0, dout_oe}, 32'd0);
    cs = 1'b0; tick(4);
    rd(8'h07, 16'h00FF, "R4");

    // erase one word
    send_head(2'b11, 8'h07); end_cs;
    tick(PROG + 50);
    rd(8'h07, 16'hFFFF, "R6");
    rd(8'h05, 16'h1234, "R6");

    // fill all
    send_head(2'b00, {2'b01, 6'b0}); send_data(16'h5A5A); end_cs;
    tick(320);
    rd(8'h00, 16'h5A5A, "R7");
    rd(8'hFF, 16'h5A5A, "R7");
    rd(8'h07, 16'h5A5A, "R11");

    // disable, then clear all is ignored
    ext(2'b00);
    send_head(2'b00, {2'b10, 6'b0}); end_cs;
    cs = 1'b1; tick(6);
    chk("R3 locked clear gives no status", {31'b0, dout_oe}, 32'd0);
    cs = 1'b0; tick(320);
    rd(8'h00, 16'h5A5A, "R3");

    // reset clears an enabled latch
    ext(2'b11);
    rst = 1'b1; tick(3); rst = 1'b0; tick(3);
    wr(8'h03, 16'h0000);
    tick(PROG + 50);
    rd(8'h03, 16'h5A5A, "R1");

    tick(20);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule